// File: doc/BRIEF.md
# Exhaustive CNF Satisfiability Search Engine

This block decides whether a formula in conjunctive normal form, held in a flat on-chip literal table, has a satisfying assignment. After a start pulse, an assignment counter walks through every candidate value of the first `n_vars` variables, starting from zero and adding one per clock. In the same cycle, combinational logic evaluates every clause of the table in parallel against the current candidate.

The search stops at the first candidate that makes every active clause true. It also stops when the whole space of 2^`n_vars` candidates has been tried without success. The engine then raises `done`, reports `sat` and, when one was found, the satisfying model. A diagnostic counter reports how many candidates were evaluated. The surrounding logic loads the literal table and the two counts, pulses `start` and waits for `done`.

The search is exhaustive by design, so the worst-case solve time is 2^`n_vars` cycles. The capacity (variables, clauses, literal slots per clause, and the width of the variable index field) is set by parameters.

Top module: `sat_search_engine`

## Requirements
- R1: Each literal slot is 6 bits wide. Bits [3:0] hold a 0-based variable index, bit 4 set means the literal is negated, and bit 5 set means the slot is in use. Slot l of clause c sits at bit offset (c*SLOT_MAX + l)*6 of `lit_table`.
- R2: A clause is true when at least one of its in-use literals is true. Slots with bit 5 clear have no effect. A variable index at or above VAR_MAX reads as the value 0.
- R3: Clauses with an index at or above the captured clause count are treated as satisfied. An active clause with no in-use slot is false, so the formula is reported unsatisfiable.
- R4: A cycle with `start` high clears `done`, `sat`, `model` and `cycles` at that clock edge and captures `n_vars` and `n_clauses`. Later changes to these two inputs do not affect the running search.
- R5: Candidates are tried in ascending numeric order from 0, so the reported model is the smallest satisfying one. In the model, bit i is the value of the variable with index i. On success, `done` and `sat` are both high, and model bits at or above `n_vars` are 0.
- R6: `cycles` counts the candidates evaluated: model + 1 on success, and 2^`n_vars` on failure. It increases by one on every clock of the search.
- R7: When no candidate in the 2^`n_vars` space succeeds, the engine sets `done` high, with `sat` low and `model` at 0.
- R8: Once `done` is high, `done`, `sat`, `model` and `cycles` hold their values until the next `start`.
- R9: While reset is asserted, `done`, `sat`, `model` and `cycles` are 0.
- R10: With `n_vars` at 0, exactly one candidate (all variables 0) is evaluated, so `cycles` ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a new search |
| n_vars | input | $clog2(VAR_MAX+1) (4) | Number of variables to sweep, captured at start |
| n_clauses | input | $clog2(CLAUSE_MAX+1) (5) | Number of active clauses, captured at start |
| lit_table | input | CLAUSE_MAX*SLOT_MAX*(IDX_W+2) (1200) | Flat literal table, held stable during a search |
| done | output | 1 | Search finished |
| sat | output | 1 | A satisfying assignment was found |
| model | output | VAR_MAX (10) | Satisfying assignment, valid when sat is high |
| cycles | output | VAR_MAX+1 (11) | Candidates evaluated in the last search |

## Verification
On every cycle, the assertions check several properties. A start clears the result. `sat` never appears without `done`. `sat` rises only after the clause evaluator has reported success. The cycle count steps by exactly one during a search, and results stay frozen after completion. The model never sets a bit outside the swept variables. Whether the reported model is the smallest satisfying assignment, how literals are encoded and ignored, how clauses beyond the count are handled, and whether the count matches 2^`n_vars` on failure all depend on formula contents. Only the bench's formula scenarios can show these.

// File: rtl/sat_pkg.sv
// Package: shared types for the exhaustive satisfiability search engine.
// Assumes nothing beyond being compiled before the modules that import it.
package sat_pkg;

    // Controller state: waiting for a start, or sweeping candidates.
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SEARCH = 1'b1
    } search_state_t;

endpackage

// File: rtl/sat_clause_eval.sv
// Module: sat_clause_eval
// Evaluates one clause: true when any in-use literal slot is true.
// Assumes slot layout {used, negated, index[IDX_W-1:0]} per slot, slot 0 in
// the low bits. An index beyond the assignment width reads as 0.
module sat_clause_eval #(
    parameter int VAR_MAX  = 10,
    parameter int SLOT_MAX = 10,
    parameter int IDX_W    = 4,
    localparam int LIT_W   = IDX_W + 2,
    localparam int PAD_W   = (VAR_MAX > (1 << IDX_W)) ? VAR_MAX : (1 << IDX_W)
) (
    input  logic [VAR_MAX-1:0]        assign_i,
    input  logic [SLOT_MAX*LIT_W-1:0] slots_i,
    output logic                      clause_true_o
);

    logic [PAD_W-1:0]    padded;
    logic [SLOT_MAX-1:0] lit_hit;

    // Zero-extend the assignment so any encodable index selects a defined bit.
    assign padded = PAD_W'(assign_i);

    for (genvar s = 0; s < SLOT_MAX; s++) begin : g_slot
        logic [LIT_W-1:0] slot;
        logic             var_val;
        assign slot    = slots_i[s*LIT_W +: LIT_W];
        // Value of the referenced variable, then polarity and in-use gating.
        assign var_val = padded[slot[IDX_W-1:0]];
        assign lit_hit[s] = slot[IDX_W+1] & (var_val ^ slot[IDX_W]);
    end

    // Clause is an OR over its literal hits.
    assign clause_true_o = |lit_hit;

endmodule

// File: rtl/sat_formula_eval.sv
// Module: sat_formula_eval
// Evaluates all clauses of the literal table in parallel against one
// candidate and reports whether every active clause holds.
// Assumes the table is stable while a search runs; clauses at or above
// n_clauses_i are treated as satisfied.
module sat_formula_eval #(
    parameter int VAR_MAX    = 10,
    parameter int CLAUSE_MAX = 20,
    parameter int SLOT_MAX   = 10,
    parameter int IDX_W      = 4,
    localparam int LIT_W     = IDX_W + 2,
    localparam int CL_W      = SLOT_MAX * LIT_W,
    localparam int CCNT_W    = $clog2(CLAUSE_MAX + 1)
) (
    input  logic [VAR_MAX-1:0]         assign_i,
    input  logic [CLAUSE_MAX*CL_W-1:0] lit_table_i,
    input  logic [CCNT_W-1:0]          n_clauses_i,
    output logic                       all_sat_o
);

    logic [CLAUSE_MAX-1:0] clause_true;
    logic [CLAUSE_MAX-1:0] clause_ok;

    for (genvar c = 0; c < CLAUSE_MAX; c++) begin : g_clause
        localparam logic [CCNT_W-1:0] C_IDX = CCNT_W'(c);

        sat_clause_eval #(
            .VAR_MAX (VAR_MAX),
            .SLOT_MAX(SLOT_MAX),
            .IDX_W   (IDX_W)
        ) i_clause (
            .assign_i     (assign_i),
            .slots_i      (lit_table_i[c*CL_W +: CL_W]),
            .clause_true_o(clause_true[c])
        );

        // Inactive clauses never block success.
        assign clause_ok[c] = clause_true[c] | (C_IDX >= n_clauses_i);
    end

    // The formula holds when every clause is either true or inactive.
    assign all_sat_o = &clause_ok;

endmodule

// File: rtl/sat_search_ctrl.sv
// Module: sat_search_ctrl
// Drives the candidate counter, counts evaluated candidates and decides when
// the search ends (first success, or the full 2^n_vars space exhausted).
// Assumes all_sat_i is a same-cycle combinational verdict on cand_o.
module sat_search_ctrl
    import sat_pkg::*;
#(
    parameter int VAR_MAX    = 10,
    parameter int CLAUSE_MAX = 20,
    localparam int VCNT_W    = $clog2(VAR_MAX + 1),
    localparam int CCNT_W    = $clog2(CLAUSE_MAX + 1),
    localparam int CYC_W     = VAR_MAX + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [VCNT_W-1:0]  n_vars_i,
    input  logic [CCNT_W-1:0]  n_clauses_i,
    input  logic               all_sat_i,
    output logic [VAR_MAX-1:0] cand_o,
    output logic [CCNT_W-1:0]  n_clauses_o,
    output logic               done_o,
    output logic               sat_o,
    output logic [VAR_MAX-1:0] model_o,
    output logic [CYC_W-1:0]   cycles_o
);

    search_state_t      state_q;
    logic [VCNT_W-1:0]  n_vars_q;
    logic [VAR_MAX-1:0] space_mask;
    logic               last_cand;

    // Mask of the swept variables; equals the last candidate of the space.
    always_comb begin
        for (int i = 0; i < VAR_MAX; i++) begin
            space_mask[i] = (VCNT_W'(i) < n_vars_q);
        end
    end

    // The current candidate is the final one of the space.
    assign last_cand = (cand_o == space_mask);

    // Search sequencing: capture on start, step per cycle, stop on result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            n_vars_q    <= '0;
            n_clauses_o <= '0;
            cand_o      <= '0;
            done_o      <= 1'b0;
            sat_o       <= 1'b0;
            model_o     <= '0;
            cycles_o    <= '0;
        end else if (start_i) begin
            state_q     <= ST_SEARCH;
            n_vars_q    <= n_vars_i;
            n_clauses_o <= n_clauses_i;
            cand_o      <= '0;
            done_o      <= 1'b0;
            sat_o       <= 1'b0;
            model_o     <= '0;
            cycles_o    <= '0;
        end else if (state_q == ST_SEARCH) begin
            cycles_o <= cycles_o + CYC_W'(1);
            if (all_sat_i) begin
                done_o  <= 1'b1;
                sat_o   <= 1'b1;
                model_o <= cand_o;
                state_q <= ST_IDLE;
            end else if (last_cand) begin
                done_o  <= 1'b1;
                state_q <= ST_IDLE;
            end else begin
                cand_o <= cand_o + VAR_MAX'(1);
            end
        end
    end

    // R4: a start leaves a cleared result on the next cycle.
    a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && !sat_o && cycles_o == '0 && model_o == '0));

    // R5: success is only reported together with completion.
    a_r5_sat_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> done_o);

    // R5: sat rises only after the evaluator reported success.
    a_r5_sat_from_eval: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_o) |-> $past(all_sat_i));

    // R5: the model never sets a variable outside the swept range.
    a_r5_model_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> ((model_o & ~space_mask) == '0));

    // R6: each search cycle adds exactly one to the count.
    a_r6_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH && !start_i) |=> (cycles_o == $past(cycles_o) + CYC_W'(1)));

    // R7: failure leaves an empty model.
    a_r7_unsat_model: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !sat_o) |-> (model_o == '0));

    // R8: results stay frozen until the next start.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(sat_o) && $stable(model_o) && $stable(cycles_o)));

endmodule

// File: rtl/sat_search_engine.sv
// Module: sat_search_engine (top)
// Exhaustive CNF satisfiability search: a counter sweeps candidates while all
// clauses are checked in parallel each cycle.
// Assumes lit_table is stable for the whole search; n_vars and n_clauses are
// captured at start. n_vars above VAR_MAX sweeps all VAR_MAX variables.
module sat_search_engine #(
    parameter int VAR_MAX    = 10,
    parameter int CLAUSE_MAX = 20,
    parameter int SLOT_MAX   = 10,
    parameter int IDX_W      = 4,
    localparam int LIT_W     = IDX_W + 2,
    localparam int TBL_W     = CLAUSE_MAX * SLOT_MAX * LIT_W,
    localparam int VCNT_W    = $clog2(VAR_MAX + 1),
    localparam int CCNT_W    = $clog2(CLAUSE_MAX + 1),
    localparam int CYC_W     = VAR_MAX + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VCNT_W-1:0]  n_vars,
    input  logic [CCNT_W-1:0]  n_clauses,
    input  logic [TBL_W-1:0]   lit_table,
    output logic               done,
    output logic               sat,
    output logic [VAR_MAX-1:0] model,
    output logic [CYC_W-1:0]   cycles
);

    logic [VAR_MAX-1:0] cand;
    logic [CCNT_W-1:0]  n_clauses_q;
    logic               all_sat;

    sat_formula_eval #(
        .VAR_MAX   (VAR_MAX),
        .CLAUSE_MAX(CLAUSE_MAX),
        .SLOT_MAX  (SLOT_MAX),
        .IDX_W     (IDX_W)
    ) i_formula (
        .assign_i   (cand),
        .lit_table_i(lit_table),
        .n_clauses_i(n_clauses_q),
        .all_sat_o  (all_sat)
    );

    sat_search_ctrl #(
        .VAR_MAX   (VAR_MAX),
        .CLAUSE_MAX(CLAUSE_MAX)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .n_vars_i   (n_vars),
        .n_clauses_i(n_clauses),
        .all_sat_i  (all_sat),
        .cand_o     (cand),
        .n_clauses_o(n_clauses_q),
        .done_o     (done),
        .sat_o      (sat),
        .model_o    (model),
        .cycles_o   (cycles)
    );

endmodule

// File: tb/test_sat_search_engine.sv
// Bench for sat_search_engine: a vector table walked by one loop, then
// directed tests for reset, encoding corners, capacity limits and restarts.
module test_sat_search_engine;

    localparam int VAR_MAX    = 10;
    localparam int CLAUSE_MAX = 20;
    localparam int SLOT_MAX   = 10;
    localparam int TBL_W      = CLAUSE_MAX * SLOT_MAX * 6;
    localparam int NVEC       = 10;

    // Columns: n_vars, n_clauses, 3 clauses x 3 literals (signed, 1-based,
    // 0 = unused slot), expected sat, expected model.
    localparam int VEC [NVEC][13] = '{
        '{3, 3,  1, 0, 0,   2, 0, 0,   3, 0, 0,  1, 7},
        '{1, 2,  1, 0, 0,  -1, 0, 0,   0, 0, 0,  0, 0},
        '{3, 3,  1, 2, 3,  -1, 2, 0,  -2, 3, 0,  1, 4},
        '{2, 1, -1,-2, 0,   0, 0, 0,   0, 0, 0,  1, 0},
        '{2, 1,  1, 0, 0,  -1, 0, 0,   0, 0, 0,  1, 1},
        '{2, 3,  1, 0, 0,   2, 0, 0,   0, 0, 0,  0, 0},
        '{0, 1, -1, 0, 0,   0, 0, 0,   0, 0, 0,  1, 0},
        '{0, 1,  1, 0, 0,   0, 0, 0,   0, 0, 0,  0, 0},
        '{4, 2,  4, 0, 0,  -3,-1, 0,   0, 0, 0,  1, 8},
        '{3, 0,  1, 0, 0,  -1, 0, 0,   0, 0, 0,  1, 0}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [3:0]         n_vars = '0;
    logic [4:0]         n_clauses = '0;
    logic [TBL_W-1:0]   lit_table = '0;
    logic               done;
    logic               sat;
    logic [VAR_MAX-1:0] model;
    logic [VAR_MAX:0]   cycles;

    int checks = 0;
    int errors = 0;

    sat_search_engine i_sat_search_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .n_vars   (n_vars),
        .n_clauses(n_clauses),
        .lit_table(lit_table),
        .done     (done),
        .sat      (sat),
        .model    (model),
        .cycles   (cycles)
    );

    always #5 clk = ~clk;

    // Compare one value and log a failure line.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Encode a signed 1-based literal into the 6-bit slot format (R1).
    function automatic logic [5:0] enc(input int d);
        int mag;
        if (d == 0) return 6'd0;
        mag = (d < 0) ? -d : d;
        return {1'b1, (d < 0), 4'(mag - 1)};
    endfunction

    task automatic set_slot(input int c, input int l, input logic [5:0] v);
        lit_table[(c*SLOT_MAX + l)*6 +: 6] = v;
    endtask

    // Pulse start, check the cleared result, then wait for done.
    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R4 done cleared", int'(done), 0);
        chk("R4 cycles cleared", int'(cycles), 0);
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("done reached", int'(done), 1);
    endtask

    task automatic expect_result(input string req, input int s, input int m, input int cy);
        chk({req, " sat"}, int'(sat), s);
        chk({req, " model"}, int'(model), m);
        chk({req, " cycles"}, int'(cycles), cy);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int held_cycles;
        // R9: reset state.
        repeat (3) @(negedge clk);
        chk("R9 done", int'(done), 0);
        chk("R9 sat", int'(sat), 0);
        chk("R9 model", int'(model), 0);
        chk("R9 cycles", int'(cycles), 0);
        rst_n = 1'b1;

        // Vector table: R1 R2 R3 R5 R6 R7 R10.
        for (int v = 0; v < NVEC; v++) begin
            int es, em, ec;
            lit_table = '0;
            for (int c = 0; c < 3; c++) begin
                for (int l = 0; l < 3; l++) begin
                    set_slot(c, l, enc(VEC[v][2 + c*3 + l]));
                end
            end
            n_vars    = 4'(VEC[v][0]);
            n_clauses = 5'(VEC[v][1]);
            es = VEC[v][11];
            em = VEC[v][12];
            ec = es ? em + 1 : (1 << VEC[v][0]);
            pulse_start();
            wait_done();
            expect_result($sformatf("R5 R6 R7 vec%0d", v), es, em, ec);
        end

        // R2: an unused slot with a live-looking literal has no effect.
        lit_table = '0;
        set_slot(0, 0, 6'b0_0_0000);
        set_slot(0, 1, enc(2));
        n_vars = 4'd2; n_clauses = 5'd1;
        pulse_start(); wait_done();
        expect_result("R2 unused slot", 1, 2, 3);

        // R2: index beyond VAR_MAX reads 0, so its negation is always true.
        lit_table = '0;
        set_slot(0, 0, 6'b1_1_1100);
        n_vars = 4'd3; n_clauses = 5'd1;
        pulse_start(); wait_done();
        expect_result("R2 high index neg", 1, 0, 1);

        lit_table = '0;
        set_slot(0, 0, 6'b1_0_1100);
        pulse_start(); wait_done();
        expect_result("R2 high index pos", 0, 0, 8);

        // R5: highest variable at full capacity.
        lit_table = '0;
        set_slot(0, 9, enc(10));
        n_vars = 4'd10; n_clauses = 5'd1;
        pulse_start(); wait_done();
        expect_result("R5 top var", 1, 512, 513);

        // R7: full 2^10 sweep, using the last clause index.
        set_slot(19, 0, enc(-10));
        n_clauses = 5'd20;
        pulse_start(); wait_done();
        expect_result("R7 full sweep", 0, 0, 1024);

        // R8: results hold while idle.
        held_cycles = int'(cycles);
        repeat (5) @(negedge clk);
        chk("R8 done held", int'(done), 1);
        chk("R8 cycles held", int'(cycles), held_cycles);
        chk("R8 sat held", int'(sat), 0);

        // R4: inputs changed after start do not affect the search.
        lit_table = '0;
        set_slot(0, 0, enc(1));
        set_slot(1, 0, enc(-1));
        n_vars = 4'd1; n_clauses = 5'd2;
        pulse_start();
        n_vars = 4'd10; n_clauses = 5'd0;
        wait_done();
        expect_result("R4 captured counts", 0, 0, 2);

        // R4: a restart after success clears and reruns.
        lit_table = '0;
        set_slot(0, 0, enc(2));
        n_vars = 4'd2; n_clauses = 5'd1;
        pulse_start(); wait_done();
        expect_result("R4 first run", 1, 2, 3);
        pulse_start();
        chk("R4 sat cleared", int'(sat), 0);
        chk("R4 model cleared", int'(model), 0);
        wait_done();
        expect_result("R4 rerun", 1, 2, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule